// File: doc/BRIEF.md
# Three-Share Masked Ripple-Carry Adder

This block adds two 32-bit words that are each held as three Boolean shares, so that the plain value of an operand is the XOR of its three shares. It produces a three-share sum, modulo 2^WIDTH, and a three-share carry-out. The carry moves through the word one bit position per clock cycle. The carry register sits between every stage, so a glitch cannot combine all three shares of a value. Each nonlinear carry share is computed from only two of the three share indices. After each stage the carry is refreshed with a zero-sum mask. The mask comes from four fresh random bits, which are captured once per addition.

A caller pulses `start` with the operand shares, the random bits and, optionally, a shared carry-in. `busy` is high while the word is being processed. The result is ready when the one-cycle `done` strobe appears, a fixed WIDTH cycles after `start` is accepted. Wider additions are built from several limbs. The shared carry-out of one limb is fed back as the shared carry-in of the next limb, and it is used for nothing else.

Top module: `mask_rca_add`

## Requirements
- R1: After reset, `busy` and `done` are 0 and all sum and carry-out shares are 0.
- R2: When `done` is 1, the XOR of the three sum shares equals (XOR of A shares) + (XOR of B shares) + carry-in, modulo 2^WIDTH, for any masks.
- R3: When `done` is 1, the XOR of the three carry-out shares equals bit WIDTH of that full-width sum.
- R4: With `cin_en` at 0, the carry-in shares are ignored and the carry-in is taken as the shared zero (0,0,0).
- R5: `done` goes high exactly WIDTH clock edges after the edge that accepts `start`, and it stays high for one cycle only.
- R6: A `start` pulse that arrives while `busy` is 1 is ignored. It does not change the running result and does not cause an extra `done`.
- R7: If the carry-out shares of one addition are fed in as carry-in shares (with `cin_en` at 1), two additions together give a correct 2*WIDTH-bit sum.
- R8: The unmasked result does not depend on the four random bits. Each carry refresh adds a mask whose three parts XOR to zero.
- R9: While the block is idle and `start` is low, the sum and carry-out shares hold their values.
- R10: `busy` is 1 from the cycle after `start` is accepted up to and including the cycle before `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an addition (accepted only when idle) |
| a_sh | input | 3 x WIDTH | Three Boolean shares of summand A |
| b_sh | input | 3 x WIDTH | Three Boolean shares of summand B |
| cin_en | input | 1 | Use the carry-in shares |
| cin_sh | input | 3 | Three shares of the carry-in |
| rnd | input | 4 | Fresh random bits for the carry refresh |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle strobe: result valid |
| sum_sh | output | 3 x WIDTH | Three shares of the sum |
| cout_sh | output | 3 | Three shares of the carry-out |

## Verification
The assertions check the timing contract on every cycle: the single-cycle `done` pulse, the fixed latency after an accepted start, `busy` dropping as `done` rises, outputs that hold while idle, and the zero-sum property of every carry refresh. Only the bench's scenarios can show the arithmetic itself. These scenarios cover correct unmasked sums and carries under random masks, carry-in gating, results that do not depend on the random bits, a start pulse during a busy period that has no effect, and a two-limb chained addition.

// File: rtl/mask_rca_pkg.sv
package mask_rca_pkg;
    localparam int NSHARE    = 3;
    localparam int RAND_BITS = 4;

    // index of the share that is 'step' positions after share i
    function automatic int share_after(input int i, input int step);
        return (i + step) % NSHARE;
    endfunction
endpackage

// File: rtl/mask_rca_maj_share.sv
// One output share of the shared majority (carry) function.
// Its inputs come from two share indices only (non-completeness).
module mask_rca_maj_share (
    input  logic a_j,
    input  logic a_k,
    input  logic b_j,
    input  logic b_k,
    input  logic c_j,
    input  logic c_k,
    output logic f
);
    logic ab, ac, bc;
    always_comb begin
        ab = (a_j & b_j) ^ (a_j & b_k) ^ (a_k & b_j);
        ac = (a_j & c_j) ^ (a_j & c_k) ^ (a_k & c_j);
        bc = (b_j & c_j) ^ (b_j & c_k) ^ (b_k & c_j);
        f  = ab ^ ac ^ bc;
    end
endmodule

// File: rtl/mask_rca_refresh.sv
// Zero-sum remask of the three carry shares; the random pair alternates with
// the parity of the bit position.
module mask_rca_refresh
    import mask_rca_pkg::*;
(
    input  logic [NSHARE-1:0]    c_in,
    input  logic [RAND_BITS-1:0] rnd,
    input  logic                 odd,
    output logic [NSHARE-1:0]    c_out
);
    logic m0, m1;
    always_comb begin
        m0       = odd ? rnd[2] : rnd[0];
        m1       = odd ? rnd[3] : rnd[1];
        c_out[0] = c_in[0] ^ m0;
        c_out[1] = c_in[1] ^ m1;
        c_out[2] = c_in[2] ^ m0 ^ m1;
    end

    always_comb begin
        AST_REFRESH_ZERO_SUM: assert ((^c_out) == (^c_in)); // R8
    end
endmodule

// File: rtl/mask_rca_add.sv
module mask_rca_add
    import mask_rca_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic [NSHARE-1:0][WIDTH-1:0]       a_sh,
    input  logic [NSHARE-1:0][WIDTH-1:0]       b_sh,
    input  logic                               cin_en,
    input  logic [NSHARE-1:0]                  cin_sh,
    input  logic [RAND_BITS-1:0]               rnd,
    output logic                               busy,
    output logic                               done,
    output logic [NSHARE-1:0][WIDTH-1:0]       sum_sh,
    output logic [NSHARE-1:0]                  cout_sh
);
    localparam int IW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [IW-1:0] LAST = IW'(WIDTH - 1);

    typedef struct packed {
        logic                         busy;
        logic                         done;
        logic [IW-1:0]                idx;
        logic [NSHARE-1:0][WIDTH-1:0] acc;  // A shares, becoming sum shares
        logic [NSHARE-1:0][WIDTH-1:0] bsh;  // B shares, shifted out
        logic [NSHARE-1:0]            cy;   // carry shares between stages
        logic [RAND_BITS-1:0]         rnd;
    } state_t;

    state_t st_d, st_q;

    logic [NSHARE-1:0] sbit, cy_raw, cy_fresh;

    // nonlinear carry shares, each built from two share indices
    for (genvar i = 0; i < NSHARE; i++) begin : g_maj
        localparam int J = share_after(i, 1);
        localparam int K = share_after(i, 2);
        mask_rca_maj_share u_maj (
            .a_j (st_q.acc[J][0]),
            .a_k (st_q.acc[K][0]),
            .b_j (st_q.bsh[J][0]),
            .b_k (st_q.bsh[K][0]),
            .c_j (st_q.cy[J]),
            .c_k (st_q.cy[K]),
            .f   (cy_raw[i])
        );
        assign sbit[i] = st_q.acc[i][0] ^ st_q.bsh[i][0] ^ st_q.cy[i];
    end

    mask_rca_refresh u_refresh (
        .c_in  (cy_raw),
        .rnd   (st_q.rnd),
        .odd   (st_q.idx[0]),
        .c_out (cy_fresh)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.acc  = a_sh;
                st_d.bsh  = b_sh;
                st_d.cy   = cin_en ? cin_sh : '0;
                st_d.rnd  = rnd;
            end
        end else begin
            for (int i = 0; i < NSHARE; i++) begin
                st_d.acc[i] = {sbit[i], st_q.acc[i][WIDTH-1:1]};
                st_d.bsh[i] = {1'b0, st_q.bsh[i][WIDTH-1:1]};
            end
            st_d.cy  = cy_fresh;
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign sum_sh  = st_q.acc;
    assign cout_sh = st_q.cy;

    // cycles since the accepted start, used by the latency check
    logic [IW:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                lat_q <= '0;
        else if (!busy && start)   lat_q <= '0;
        else if (busy)             lat_q <= lat_q + 1'b1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == (IW+1)'(WIDTH))); // R5
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(sum_sh) && $stable(cout_sh))); // R9
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && (lat_q < (IW+1)'(WIDTH - 1))) |=> busy); // R6
endmodule

// File: tb/sim_mask_rca_add.sv
module sim_mask_rca_add;
    localparam int W = 32;
    localparam time PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0][W-1:0] a_sh = '0;
    logic [2:0][W-1:0] b_sh = '0;
    logic cin_en = 1'b0;
    logic [2:0] cin_sh = '0;
    logic [3:0] rnd = '0;
    logic busy, done;
    logic [2:0][W-1:0] sum_sh;
    logic [2:0] cout_sh;

    int n_chk = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    mask_rca_add #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .a_sh(a_sh), .b_sh(b_sh),
        .cin_en(cin_en), .cin_sh(cin_sh), .rnd(rnd), .busy(busy), .done(done),
        .sum_sh(sum_sh), .cout_sh(cout_sh)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] unmask(input logic [2:0][W-1:0] s);
        return s[0] ^ s[1] ^ s[2];
    endfunction

    function automatic logic [2:0][W-1:0] share(input logic [W-1:0] v);
        logic [2:0][W-1:0] s;
        s[0] = $urandom;
        s[1] = $urandom;
        s[2] = v ^ s[0] ^ s[1];
        return s;
    endfunction

    // runs one addition; returns unmasked sum, unmasked carry and latency
    task automatic add_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic en, input logic [2:0] cin, input logic [3:0] r,
                          input logic poke,
                          output logic [W-1:0] s, output logic c, output int cyc);
        @(negedge clk);
        a_sh = share(a); b_sh = share(b); cin_en = en; cin_sh = cin; rnd = r;
        start = 1'b1;
        cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = 1'b0;
            if (poke && cyc == 5) begin
                a_sh = share(~a); b_sh = share(32'h1234_5678); rnd = ~r;
                start = 1'b1;
            end
            if (done || cyc > 200) break;
        end
        start = 1'b0;
        s = unmask(sum_sh);
        c = ^cout_sh;
    endtask

    task automatic t_reset;
        check("R1 busy", {63'd0, busy}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 sum", {32'd0, sum_sh[0] | sum_sh[1] | sum_sh[2]}, 64'd0);
        check("R1 cout", {61'd0, cout_sh}, 64'd0);
    endtask

    task automatic t_basic(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] s; logic c; int cyc;
        logic [W:0] e;
        e = {1'b0, a} + {1'b0, b};
        add_op(a, b, 1'b1, 3'b000, 4'($urandom), 1'b0, s, c, cyc);
        check("R2 sum", {32'd0, s}, {32'd0, e[W-1:0]});
        check("R3 cout", {63'd0, c}, {63'd0, e[W]});
        // done seen at negedge after WIDTH edges past the capture edge
        check("R5 latency", 64'(cyc), 64'(W + 1));
        @(negedge clk);
        check("R5 done one cycle", {63'd0, done}, 64'd0);
    endtask

    task automatic t_cin_gate;
        logic [W-1:0] s; logic c; int cyc;
        // shares 1,0,0 mean carry-in 1, but cin_en=0
        add_op(32'hFFFF_FFFF, 32'h0, 1'b0, 3'b001, 4'hA, 1'b0, s, c, cyc);
        check("R4 sum ignored cin", {32'd0, s}, 64'hFFFF_FFFF);
        check("R4 cout ignored cin", {63'd0, c}, 64'd0);
        // same with cin_en=1 and carry-in shares 1,1,1 (value 1)
        add_op(32'hFFFF_FFFF, 32'h0, 1'b1, 3'b111, 4'h5, 1'b0, s, c, cyc);
        check("R2 sum with cin", {32'd0, s}, 64'd0);
        check("R3 cout with cin", {63'd0, c}, 64'd1);
    endtask

    task automatic t_rand_indep;
        logic [W-1:0] s0, s1; logic c0, c1; int cyc;
        add_op(32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0, 3'b000, 4'h0, 1'b0, s0, c0, cyc);
        add_op(32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0, 3'b000, 4'hF, 1'b0, s1, c1, cyc);
        check("R8 sum vs rnd", {32'd0, s1}, {32'd0, s0});
        check("R8 cout vs rnd", {63'd0, c1}, {63'd0, c0});
        check("R8 sum value", {32'd0, s1}, {32'd0, 32'hDEAD_BEEF + 32'hCAFE_F00D});
    endtask

    task automatic t_busy_start;
        logic [W-1:0] s; logic c; int cyc; int extra;
        add_op(32'h8000_0001, 32'h8000_0001, 1'b0, 3'b000, 4'h3, 1'b1, s, c, cyc);
        check("R6 sum unaffected", {32'd0, s}, 64'h2);
        check("R6 cout unaffected", {63'd0, c}, 64'd1);
        check("R6 latency unaffected", 64'(cyc), 64'(W + 1));
        extra = 0;
        for (int i = 0; i < W + 4; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R6 no extra done", 64'(extra), 64'd0);
        check("R10 idle after", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_busy_flag;
        int hi;
        @(negedge clk);
        a_sh = share(32'h1); b_sh = share(32'h2); cin_en = 1'b0; start = 1'b1;
        hi = 0;
        @(negedge clk);
        start = 1'b0;
        while (!done && hi < 200) begin
            if (busy) hi++;
            @(negedge clk);
        end
        check("R10 busy length", 64'(hi), 64'(W));
        check("R10 busy low at done", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_hold;
        logic [W-1:0] s0; logic c0;
        s0 = unmask(sum_sh); c0 = ^cout_sh;
        a_sh = share(32'h5555_5555);
        repeat (6) @(negedge clk);
        check("R9 sum held", {32'd0, unmask(sum_sh)}, {32'd0, s0});
        check("R9 cout held", {63'd0, ^cout_sh}, {63'd0, c0});
    endtask

    task automatic t_chain(input logic [63:0] a, input logic [63:0] b);
        logic [W-1:0] lo, hi; logic c; int cyc;
        logic [2:0] csh;
        logic [64:0] e;
        e = {1'b0, a} + {1'b0, b};
        add_op(a[31:0], b[31:0], 1'b0, 3'b000, 4'($urandom), 1'b0, lo, c, cyc);
        csh = cout_sh;
        add_op(a[63:32], b[63:32], 1'b1, csh, 4'($urandom), 1'b0, hi, c, cyc);
        check("R7 chained sum", {hi, lo}, e[63:0]);
        check("R7 chained cout", {63'd0, c}, {63'd0, e[64]});
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic(32'h0000_0001, 32'h0000_0002);
        t_basic(32'hFFFF_FFFF, 32'h0000_0001);
        t_basic(32'h7FFF_FFFF, 32'h7FFF_FFFF);
        t_basic(32'h0, 32'h0);
        for (int i = 0; i < 8; i++) t_basic(32'($urandom), 32'($urandom));
        t_cin_gate();
        t_rand_indep();
        t_busy_start();
        t_busy_flag();
        t_hold();
        t_chain(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
        t_chain(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
        t_chain({32'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)});
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule